// File: doc/BRIEF.md
# Multi-format pixel colour expander

The expander sits between the frame-store read path and the display output. Each cycle it may accept one raw 32-bit pixel word, a 4-bit window format code, a 4-bit palette bank number and a gamma-bypass flag. It turns the word into one byte each for alpha, red, green and blue. Packed direct-colour words are split into channel fields, and each narrow field is widened to eight bits. An 8-bit index word is looked up in a 1024-entry, 32-bit colour table. The bank number picks one of sixteen 64-entry regions of that table. A host port loads the table.

Bit 2 of the format code marks a window whose pixels skip the colour table. For an indexed window the index byte is then shown as a grey level. Direct formats never use the table, so the bit does not change them. The gamma-bypass flag is not applied here. It is carried alongside the pixel so that the downstream gamma stage can act on it. The pipeline has a fixed latency of two cycles and no stall input. This latency is exported as `PCX_LATENCY` in the package.

Top module: `pixel_color_expander`

## Requirements
- R1: `out_valid` rises exactly two clock cycles after `in_valid` is sampled high. A pixel offered every cycle comes out every cycle, in order. `out_valid` is low in any cycle that had no input two cycles earlier.
- R2: After reset, `out_valid`, `wr_reject`, `out_gamma_off` and all four colour bytes are zero.
- R3: Format 0x0 takes red from bits [7:0], green from [15:8] and blue from [23:16], and gives alpha 0xFF. Format 0x3 uses the same colour fields and takes alpha from bits [31:24].
- R4: Format 0x1 takes red from [4:0], green from [10:5] and blue from [15:11]. Each field is widened by repeating its top bits into the freed low bits, so that a full-scale field gives 0xFF.
- R5: Format 0x2 takes red from [4:0], green from [9:5] and blue from [14:10], each widened as in R4. Alpha is 0xFF when bit 15 is 1 and 0x00 when it is 0.
- R6: Format 0x9 takes red from [2:0], green from [5:3] and blue from [7:6], each widened by repetition, and gives alpha 0xFF.
- R7: Format 0xA reads table entry ((bank << 6) + pixel[7:0]) mod 1024. The entry supplies alpha [31:24], red [23:16], green [15:8] and blue [7:0].
- R8: When bit 2 of the format code is set, an indexed pixel (0xE) gives red = green = blue = pixel[7:0] and alpha 0xFF. Direct formats with bit 2 set (0x4, 0x5, 0x6, 0x7, 0xD) give the same output as the same format with bit 2 clear.
- R9: Codes with no defined format (0x8, 0xB, 0xC, 0xF) still produce `out_valid`, with all four colour bytes zero.
- R10: A host write with `wr_index` from 0 to 1023 stores `wr_data` in that entry. A write with a larger index changes no entry. `wr_reject` is high in the cycle after such a write and low otherwise.
- R11: A pixel that reads an entry in the same cycle that the host writes it gets the old contents. A read one cycle later gets the new contents.
- R12: `out_gamma_off` carries the `in_gamma_off` value of the pixel now shown on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A pixel is offered this cycle |
| in_pixel | input | 32 | Raw pixel word from the frame store |
| in_fmt | input | 4 | Window format code; bit 2 bypasses the colour table |
| in_bank | input | 4 | Palette bank, selects a 64-entry region of the table |
| in_gamma_off | input | 1 | Gamma-bypass flag for this pixel |
| wr_en | input | 1 | Host colour-table write strobe |
| wr_index | input | 11 | Host write index; values above 1023 are rejected |
| wr_data | input | 32 | Host write data, alpha/red/green/blue from the top byte down |
| wr_reject | output | 1 | Out-of-range host write seen in the previous cycle |
| out_valid | output | 1 | Output colour is valid |
| out_alpha | output | 8 | Alpha byte |
| out_red | output | 8 | Red byte |
| out_green | output | 8 | Green byte |
| out_blue | output | 8 | Blue byte |
| out_gamma_off | output | 1 | Gamma-bypass flag travelling with the pixel |

## Verification
The bench loads every full-scale field and checks for 0xFF. A design that shifts fields without repeating their top bits would show 0xF8 or 0xFC there, and a swapped field layout shows up as wrong channels in the mid-value patterns. It reads banks near the top of the table to catch an address built by OR instead of addition, or one that fails to wrap. It writes index 1024+7 to catch a design that truncates the index and overwrites entry 7. It reads and writes the same entry in one cycle, which exposes a table that forwards the new data instead of returning the old. It also runs back-to-back pixels, an indexed window with the bypass bit, and direct windows with the bypass bit. These show a pipeline that drops or repeats a beat, and a bypass bit that wrongly changes direct formats.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  localparam int unsigned PCX_LATENCY = 2;
  localparam int unsigned BYPASS_BIT  = 2;

  localparam logic [3:0] FMT_RGB24  = 4'h0;
  localparam logic [3:0] FMT_565    = 4'h1;
  localparam logic [3:0] FMT_1555   = 4'h2;
  localparam logic [3:0] FMT_ARGB32 = 4'h3;
  localparam logic [3:0] FMT_332    = 4'h9;
  localparam logic [3:0] FMT_INDEX8 = 4'hA;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } argb_t;

  typedef enum logic [1:0] {
    SRC_DIRECT = 2'd0,
    SRC_TABLE  = 2'd1,
    SRC_GREY   = 2'd2,
    SRC_NONE   = 2'd3
  } src_e;
endpackage

// File: rtl/pcx_direct_widen.sv
module pcx_direct_widen
  import pcx_pkg::*;
(
  input  logic [31:0] pix,
  input  logic [3:0]  fmt_base,
  output argb_t       color,
  output logic        known
);
  always_comb begin
    color = '0;
    known = 1'b1;
    case (fmt_base)
      FMT_RGB24: begin
        color.a = 8'hFF;
        color.r = pix[7:0];
        color.g = pix[15:8];
        color.b = pix[23:16];
      end
      FMT_ARGB32: begin
        color.a = pix[31:24];
        color.r = pix[7:0];
        color.g = pix[15:8];
        color.b = pix[23:16];
      end
      FMT_565: begin
        color.a = 8'hFF;
        color.r = {pix[4:0], pix[4:2]};
        color.g = {pix[10:5], pix[10:9]};
        color.b = {pix[15:11], pix[15:13]};
      end
      FMT_1555: begin
        color.a = {8{pix[15]}};
        color.r = {pix[4:0], pix[4:2]};
        color.g = {pix[9:5], pix[9:7]};
        color.b = {pix[14:10], pix[14:12]};
      end
      FMT_332: begin
        color.a = 8'hFF;
        color.r = {pix[2:0], pix[2:0], pix[2:1]};
        color.g = {pix[5:3], pix[5:3], pix[5:4]};
        color.b = {4{pix[7:6]}};
      end
      default: known = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcx_color_table.sv
module pcx_color_table #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Read and write share one edge, so a same-entry read returns the old word.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pcx_wr_guard.sv
module pcx_wr_guard #(
  parameter int unsigned IDX_W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [IDX_W:0] wr_index,
  output logic           wr_ok,
  output logic           wr_reject
);
  logic over_range;
  logic reject_d;

  always_comb begin
    over_range = wr_index[IDX_W];
    wr_ok      = wr_en && !over_range;
    reject_d   = wr_en && over_range;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_reject <= 1'b0;
    else        wr_reject <= reject_d;
  end

  assert_reject_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_index[IDX_W]) |=> wr_reject);
  assert_reject_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_index[IDX_W]) |=> !wr_reject);
endmodule

// File: rtl/pixel_color_expander.sv
module pixel_color_expander
  import pcx_pkg::*;
#(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned BANK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      in_pixel,
  input  logic [3:0]       in_fmt,
  input  logic [BANK_W-1:0] in_bank,
  input  logic             in_gamma_off,
  input  logic             wr_en,
  input  logic [IDX_W:0]   wr_index,
  input  logic [31:0]      wr_data,
  output logic             wr_reject,
  output logic             out_valid,
  output logic [7:0]       out_alpha,
  output logic [7:0]       out_red,
  output logic [7:0]       out_green,
  output logic [7:0]       out_blue,
  output logic             out_gamma_off
);
  localparam int unsigned SLOT_W = IDX_W - BANK_W;
  localparam int unsigned DATA_W = 32;

  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rst_sync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  // Host write path.
  logic wr_ok;
  pcx_wr_guard #(.IDX_W(IDX_W)) i_guard (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_index(wr_index),
    .wr_ok(wr_ok), .wr_reject(wr_reject)
  );

  // Table address: bank base plus index byte, wrapping at the table size.
  logic [IDX_W-1:0]  rd_addr;
  logic [DATA_W-1:0] tbl_word;
  always_comb begin
    rd_addr = IDX_W'({in_bank, {SLOT_W{1'b0}}}) + IDX_W'(in_pixel[7:0]);
  end

  pcx_color_table #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_table (
    .clk(clk), .we(wr_ok), .waddr(wr_index[IDX_W-1:0]), .wdata(wr_data),
    .re(in_valid), .raddr(rd_addr), .rdata(tbl_word)
  );

  // Stage 1: capture the pixel alongside the table read.
  logic        s1_valid, s1_valid_d;
  logic [31:0] s1_pix, s1_pix_d;
  logic [3:0]  s1_fmt, s1_fmt_d;
  logic        s1_gam, s1_gam_d;

  always_comb begin
    s1_valid_d = in_valid;
    s1_pix_d   = in_valid ? in_pixel     : s1_pix;
    s1_fmt_d   = in_valid ? in_fmt       : s1_fmt;
    s1_gam_d   = in_valid ? in_gamma_off : s1_gam;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      s1_valid <= 1'b0;
      s1_pix   <= '0;
      s1_fmt   <= '0;
      s1_gam   <= 1'b0;
    end else begin
      s1_valid <= s1_valid_d;
      s1_pix   <= s1_pix_d;
      s1_fmt   <= s1_fmt_d;
      s1_gam   <= s1_gam_d;
    end
  end

  // Stage 2: choose the colour source.
  logic [3:0] fmt_base;
  logic       bypass;
  argb_t      direct_c;
  logic       direct_known;
  src_e       src;
  argb_t      color_d;

  always_comb begin
    fmt_base = s1_fmt;
    fmt_base[BYPASS_BIT] = 1'b0;
    bypass = s1_fmt[BYPASS_BIT];
  end

  pcx_direct_widen i_widen (
    .pix(s1_pix), .fmt_base(fmt_base), .color(direct_c), .known(direct_known)
  );

  always_comb begin
    if (fmt_base == FMT_INDEX8) src = bypass ? SRC_GREY : SRC_TABLE;
    else if (direct_known)      src = SRC_DIRECT;
    else                        src = SRC_NONE;
    case (src)
      SRC_DIRECT: color_d = direct_c;
      SRC_TABLE:  color_d = argb_t'(tbl_word);
      SRC_GREY:   color_d = '{a: 8'hFF, r: s1_pix[7:0], g: s1_pix[7:0], b: s1_pix[7:0]};
      default:    color_d = '0;
    endcase
  end

  argb_t color_q, color_nx;
  logic  out_valid_d, gam_nx;

  always_comb begin
    out_valid_d = s1_valid;
    color_nx    = s1_valid ? color_d : color_q;
    gam_nx      = s1_valid ? s1_gam  : out_gamma_off;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid     <= 1'b0;
      color_q       <= '0;
      out_gamma_off <= 1'b0;
    end else begin
      out_valid     <= out_valid_d;
      color_q       <= color_nx;
      out_gamma_off <= gam_nx;
    end
  end

  assign out_alpha = color_q.a;
  assign out_red   = color_q.r;
  assign out_green = color_q.g;
  assign out_blue  = color_q.b;

  // Checks beside the pipeline.
  assert_stage1_R1: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> s1_valid);
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_q)
    s1_valid |=> out_valid);
  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_q)
    !s1_valid |=> !out_valid);
  assert_fullscale_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (s1_valid && s1_fmt == FMT_565 && s1_pix[15:0] == 16'hFFFF)
      |=> (out_red == 8'hFF && out_green == 8'hFF && out_blue == 8'hFF));
  assert_alpha_bit_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (s1_valid && s1_fmt == FMT_1555) |=> (out_alpha == 8'h00 || out_alpha == 8'hFF));
  assert_undef_zero_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (s1_valid && s1_fmt == 4'h8)
      |=> (out_alpha == 8'h00 && out_red == 8'h00 && out_green == 8'h00 && out_blue == 8'h00));
  assert_gamma_flag_R12: assert property (@(posedge clk) disable iff (!rst_q)
    s1_valid |=> (out_gamma_off == $past(s1_gam)));
endmodule

// File: tb/test_pixel_color_expander.sv
module test_pixel_color_expander;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_pixel;
  logic [3:0]  in_fmt;
  logic [3:0]  in_bank;
  logic        in_gamma_off;
  logic        wr_en;
  logic [10:0] wr_index;
  logic [31:0] wr_data;
  logic        wr_reject;
  logic        out_valid;
  logic [7:0]  out_alpha, out_red, out_green, out_blue;
  logic        out_gamma_off;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pixel_color_expander i_pixel_color_expander (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pixel(in_pixel),
    .in_fmt(in_fmt), .in_bank(in_bank), .in_gamma_off(in_gamma_off),
    .wr_en(wr_en), .wr_index(wr_index), .wr_data(wr_data),
    .wr_reject(wr_reject), .out_valid(out_valid), .out_alpha(out_alpha),
    .out_red(out_red), .out_green(out_green), .out_blue(out_blue),
    .out_gamma_off(out_gamma_off)
  );

  // Reference widening: shift up, fill from the top bits.
  function automatic logic [7:0] wid5(input logic [4:0] x);
    return (8'(x) << 3) | (8'(x) >> 2);
  endfunction
  function automatic logic [7:0] wid6(input logic [5:0] x);
    return (8'(x) << 2) | (8'(x) >> 4);
  endfunction
  function automatic logic [7:0] wid3(input logic [2:0] x);
    return (8'(x) << 5) | (8'(x) << 2) | (8'(x) >> 1);
  endfunction
  function automatic logic [7:0] wid2(input logic [1:0] x);
    return 8'(x) * 8'h55;
  endfunction

  function automatic logic [31:0] argb(input logic [7:0] a, r, g, b);
    return {a, r, g, b};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] got();
    return {out_alpha, out_red, out_green, out_blue};
  endfunction

  // Drive on the falling edge; the result is sampled two falling edges later.
  task automatic pixel(input logic [3:0] fmt, input logic [3:0] bank,
                       input logic [31:0] pix, input logic gam,
                       input logic [31:0] exp, input string tag);
    in_valid = 1'b1; in_fmt = fmt; in_bank = bank; in_pixel = pix; in_gamma_off = gam;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check({tag, " valid"}, 32'(out_valid), 32'd1);
    check(tag, got(), exp);
  endtask

  task automatic host_write(input logic [10:0] idx, input logic [31:0] data);
    wr_en = 1'b1; wr_index = idx; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset_R2();
    check("R2 out_valid", 32'(out_valid), 32'd0);
    check("R2 wr_reject", 32'(wr_reject), 32'd0);
    check("R2 gamma", 32'(out_gamma_off), 32'd0);
    check("R2 colour", got(), 32'd0);
  endtask

  task automatic t_wide_R3();
    pixel(4'h0, 4'h0, 32'h7F332211, 1'b0, argb(8'hFF, 8'h11, 8'h22, 8'h33), "R3 rgb24");
    pixel(4'h3, 4'h0, 32'h80665544, 1'b0, argb(8'h80, 8'h44, 8'h55, 8'h66), "R3 argb32");
  endtask

  task automatic t_565_R4();
    logic [15:0] p;
    p = {5'h07, 6'h2A, 5'h10};
    pixel(4'h1, 4'h0, {16'hDEAD, p}, 1'b0,
          argb(8'hFF, wid5(5'h10), wid6(6'h2A), wid5(5'h07)), "R4 565 mid");
    pixel(4'h1, 4'h0, 32'h0000FFFF, 1'b0, argb(8'hFF, 8'hFF, 8'hFF, 8'hFF), "R4 565 full");
    pixel(4'h1, 4'h0, 32'h00000000, 1'b0, argb(8'hFF, 8'h00, 8'h00, 8'h00), "R4 565 zero");
  endtask

  task automatic t_1555_R5();
    pixel(4'h2, 4'h0, {16'h0, 1'b1, 5'h03, 5'h1F, 5'h12}, 1'b0,
          argb(8'hFF, wid5(5'h12), 8'hFF, wid5(5'h03)), "R5 1555 opaque");
    pixel(4'h2, 4'h0, {16'h0, 1'b0, 5'h18, 5'h01, 5'h0A}, 1'b0,
          argb(8'h00, wid5(5'h0A), wid5(5'h01), wid5(5'h18)), "R5 1555 clear");
  endtask

  task automatic t_332_R6();
    pixel(4'h9, 4'h0, {24'h0, 2'b10, 3'b011, 3'b101}, 1'b0,
          argb(8'hFF, wid3(3'b101), wid3(3'b011), wid2(2'b10)), "R6 332");
    pixel(4'h9, 4'h0, 32'h000000FF, 1'b0, argb(8'hFF, 8'hFF, 8'hFF, 8'hFF), "R6 332 full");
  endtask

  task automatic t_index_R7();
    host_write(11'd197, 32'hA1B2C3D4);
    host_write(11'd133, 32'h0F1E2D3C);
    host_write(11'd1023, 32'h5566AA77);
    pixel(4'hA, 4'h3, 32'h00000005, 1'b0, 32'hA1B2C3D4, "R7 bank3 idx5");
    pixel(4'hA, 4'hF, 32'h000000C5, 1'b0, 32'h0F1E2D3C, "R7 wrap");
    pixel(4'hA, 4'hF, 32'h0000003F, 1'b0, 32'h5566AA77, "R7 top entry");
  endtask

  task automatic t_bypass_R8();
    pixel(4'hE, 4'h3, 32'h0000005A, 1'b0, argb(8'hFF, 8'h5A, 8'h5A, 8'h5A), "R8 grey");
    pixel(4'h5, 4'h0, {16'h0, 5'h07, 6'h2A, 5'h10}, 1'b0,
          argb(8'hFF, wid5(5'h10), wid6(6'h2A), wid5(5'h07)), "R8 565 bypass");
    pixel(4'h7, 4'h0, 32'h80665544, 1'b0, argb(8'h80, 8'h44, 8'h55, 8'h66), "R8 argb32 bypass");
  endtask

  task automatic t_undef_R9();
    pixel(4'h8, 4'h0, 32'hFFFFFFFF, 1'b0, 32'h0, "R9 code 8");
    pixel(4'hF, 4'h0, 32'hFFFFFFFF, 1'b0, 32'h0, "R9 code F");
  endtask

  task automatic t_reject_R10();
    host_write(11'd7, 32'h11223344);
    wr_en = 1'b1; wr_index = 11'd1031; wr_data = 32'hDEADBEEF;
    @(negedge clk);
    wr_en = 1'b0;
    check("R10 reject high", 32'(wr_reject), 32'd1);
    @(negedge clk);
    check("R10 reject clears", 32'(wr_reject), 32'd0);
    pixel(4'hA, 4'h0, 32'h00000007, 1'b0, 32'h11223344, "R10 entry 7 kept");
    host_write(11'd1023, 32'h01020304);
    check("R10 good write no reject", 32'(wr_reject), 32'd0);
    pixel(4'hA, 4'hF, 32'h0000003F, 1'b0, 32'h01020304, "R10 entry 1023 stored");
  endtask

  task automatic t_rdw_R11();
    host_write(11'd300, 32'hCAFE0001);
    wr_en = 1'b1; wr_index = 11'd300; wr_data = 32'hCAFE0002;
    in_valid = 1'b1; in_fmt = 4'hA; in_bank = 4'h4; in_pixel = 32'd44; in_gamma_off = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R11 old data", got(), 32'hCAFE0001);
    pixel(4'hA, 4'h4, 32'd44, 1'b0, 32'hCAFE0002, "R11 new data");
  endtask

  task automatic t_gamma_R12();
    pixel(4'h0, 4'h0, 32'h00010203, 1'b1, argb(8'hFF, 8'h03, 8'h02, 8'h01), "R12 pixel");
    check("R12 flag set", 32'(out_gamma_off), 32'd1);
    pixel(4'h0, 4'h0, 32'h00010203, 1'b0, argb(8'hFF, 8'h03, 8'h02, 8'h01), "R12 pixel2");
    check("R12 flag clear", 32'(out_gamma_off), 32'd0);
  endtask

  task automatic t_stream_R1();
    in_valid = 1'b1; in_fmt = 4'h0; in_bank = 4'h0; in_gamma_off = 1'b0;
    in_pixel = 32'h00000011;
    @(negedge clk);
    check("R1 gap before", 32'(out_valid), 32'd0);
    in_pixel = 32'h00000022;
    @(negedge clk);
    in_pixel = 32'h00000033;
    check("R1 beat0", got(), argb(8'hFF, 8'h11, 8'h00, 8'h00));
    check("R1 beat0 valid", 32'(out_valid), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 beat1", got(), argb(8'hFF, 8'h22, 8'h00, 8'h00));
    @(negedge clk);
    check("R1 beat2", got(), argb(8'hFF, 8'h33, 8'h00, 8'h00));
    check("R1 beat2 valid", 32'(out_valid), 32'd1);
    @(negedge clk);
    check("R1 idle after", 32'(out_valid), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_pixel = '0; in_fmt = '0; in_bank = '0;
    in_gamma_off = 1'b0; wr_en = 1'b0; wr_index = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    t_reset_R2();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_R2();
    t_wide_R3();
    t_565_R4();
    t_1555_R5();
    t_332_R6();
    t_index_R7();
    t_bypass_R8();
    t_undef_R9();
    t_reject_R10();
    t_rdw_R11();
    t_gamma_R12();
    t_stream_R1();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule